// File: doc/BRIEF.md
# Six-Channel Wavetable Sound Register Interface

This block holds the programmable state of a six-channel wavetable sound generator. A processor-side write bus (strobe, 4-bit register index, 8-bit data) reaches a small set of global registers and, through a channel-select register, one set of per-channel registers. Each channel keeps a 12-bit pitch value, a 5-bit volume, a stereo balance byte, a 2-bit table-access mode, a 32-entry table of 5-bit samples, a 5-bit table address counter and a direct-output sample. The two highest channels also keep a noise control byte.

Samples are written one at a time through a data register. Where each one lands is set by the channel's address counter, and the channel's mode decides whether the counter moves, is held at zero, or is bypassed. A per-channel step input, supplied by the playback timing logic outside this block, advances the counter of a playing channel. Channel 1's effective pitch is its own pitch plus channel 2's current sample, scaled by a global modulation setting. Every piece of state is presented on flat output buses so the playback, noise and mixing logic can read it directly.

Top module: `wt_regif`

## Requirements
- R1: After a synchronous active-low reset every output is zero: pitches, volumes, balances, modes, address counters, samples, direct outputs, noise bytes, master volume, modulation rate, modulation setting, hold flag and the effective pitch.
- R2: A write to index 0 stores data[2:0] as the selected channel; values 0 to 5 pick channel 1 to 6. Writes to indices 2 to 7 change only the selected channel, and while the selection is 6 or 7 they change nothing. Indices 10 to 15 are ignored.
- R3: A write to index 2 sets bits 7:0 of the selected channel's pitch and a write to index 3 sets bits 11:8 from data[3:0]; the new value is on the output one clock after the write.
- R4: A write to index 4 sets the selected channel's mode from data[7:6] (0 = advancing load, 1 = address reset, 2 = play, 3 = direct) and its volume from data[4:0]; a write to index 5 sets its balance byte.
- R5: In mode 0, a write to index 6 stores data[4:0] at the table entry the counter points to and advances the counter by one, wrapping from 31 to 0.
- R6: A write to index 4 that selects mode 1 clears the counter at the next clock, and the counter stays 0 for as long as the mode is 1; index-6 writes in that mode store at entry 0.
- R7: In mode 2 an index-6 write stores at the current entry without advancing, and a step pulse advances the counter by one; when both fall in the same cycle the sample lands at the old address and the counter moves by exactly one.
- R8: In mode 3 an index-6 write puts data[4:0] on the channel's direct output and leaves the table and the counter untouched.
- R9: A write to index 7 stores the noise byte only when channel 5 or 6 is selected; with any other channel selected it has no effect.
- R10: A write to index 1 sets the master volume byte, index 8 sets the modulation rate byte, and index 9 sets the modulation setting from data[1:0] and the hold flag from data[7].
- R11: While the hold flag is 1, channel 2's counter is forced to 0 at every clock, whatever its mode and step input.
- R12: When the modulation setting is nonzero and channels 1 and 2 are both in mode 2, channel 1's effective pitch is (pitch + (channel 2 sample shifted left by 0, 4 or 8 for settings 1, 2, 3)) modulo 4096; otherwise it equals channel 1's pitch.
- R13: Each channel's sample output is the table entry its counter points to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Register index |
| wr_data | input | 8 | Write data |
| step | input | 6 | Per-channel counter advance pulse, bit i for channel i+1 |
| master_vol | output | 8 | Master volume byte |
| lfo_rate | output | 8 | Modulation rate byte |
| lfo_mode | output | 2 | Modulation setting |
| lfo_hold | output | 1 | Channel 2 counter hold flag |
| ch_freq | output | 72 | Pitch per channel, 12 bits each, channel 1 lowest |
| ch_vol | output | 30 | Volume per channel, 5 bits each |
| ch_bal | output | 48 | Balance per channel, 8 bits each |
| ch_mode | output | 12 | Table-access mode per channel, 2 bits each |
| ch_addr | output | 30 | Table address counter per channel, 5 bits each |
| ch_sample | output | 30 | Current table sample per channel, 5 bits each |
| ch_direct | output | 30 | Direct-output sample per channel, 5 bits each |
| noise_ctl | output | 16 | Noise byte of channel 5 (bits 7:0) and channel 6 (bits 15:8) |
| ch1_freq_eff | output | 12 | Channel 1 pitch after modulation |

## Verification
Two counter events can fall in the same cycle: a data write to a playing channel and that channel's step pulse, and for channel 2 also the hold flag against a step. The bench drives a data write and a step in the same cycle on channel 2 in play mode. It then checks that the counter moved by one, and it walks the counter all the way round to show that the sample sits at the old address. It also steps channel 2 while the hold flag is set and checks that the counter stays at zero. A long random stream of writes and steps is compared every clock against a behavioural model that resolves each such overlap by the rules above.

// File: rtl/wt_pkg.sv
package wt_pkg;

    localparam int NUM_CH    = 6;
    localparam int FREQ_W    = 12;
    localparam int SAMP_W    = 5;
    localparam int VOL_W     = 5;
    localparam int TBL_DEPTH = 32;
    localparam int TBL_AW    = $clog2(TBL_DEPTH);
    localparam int LFO_SHIFT = 4;

    // register indices on the write bus
    localparam logic [3:0] IDX_SEL   = 4'd0;
    localparam logic [3:0] IDX_MVOL  = 4'd1;
    localparam logic [3:0] IDX_FLO   = 4'd2;
    localparam logic [3:0] IDX_FHI   = 4'd3;
    localparam logic [3:0] IDX_CTL   = 4'd4;
    localparam logic [3:0] IDX_BAL   = 4'd5;
    localparam logic [3:0] IDX_DAT   = 4'd6;
    localparam logic [3:0] IDX_NOISE = 4'd7;
    localparam logic [3:0] IDX_LRATE = 4'd8;
    localparam logic [3:0] IDX_LCTL  = 4'd9;

    typedef enum logic [1:0] {
        WM_AUTO   = 2'd0,
        WM_RESET  = 2'd1,
        WM_PLAY   = 2'd2,
        WM_DIRECT = 2'd3
    } wmode_e;

    typedef struct packed {
        logic flo;
        logic fhi;
        logic ctl;
        logic bal;
        logic dat;
        logic noise;
    } cstb_t;

    typedef struct packed {
        logic sel;
        logic mvol;
        logic lrate;
        logic lctl;
    } gstb_t;

endpackage

// File: rtl/wt_regdec.sv
module wt_regdec
    import wt_pkg::*;
(
    input  logic       wr_en_i,
    input  logic [3:0] wr_addr_i,
    output gstb_t      gstb_o,
    output cstb_t      cstb_o
);

    always_comb begin
        gstb_o = '0;
        cstb_o = '0;
        if (wr_en_i) begin
            unique case (wr_addr_i)
                IDX_SEL:   gstb_o.sel   = 1'b1;
                IDX_MVOL:  gstb_o.mvol  = 1'b1;
                IDX_LRATE: gstb_o.lrate = 1'b1;
                IDX_LCTL:  gstb_o.lctl  = 1'b1;
                IDX_FLO:   cstb_o.flo   = 1'b1;
                IDX_FHI:   cstb_o.fhi   = 1'b1;
                IDX_CTL:   cstb_o.ctl   = 1'b1;
                IDX_BAL:   cstb_o.bal   = 1'b1;
                IDX_DAT:   cstb_o.dat   = 1'b1;
                IDX_NOISE: cstb_o.noise = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/wt_lfo.sv
module wt_lfo
    import wt_pkg::*;
#(
    parameter int FW  = FREQ_W,
    parameter int SW  = SAMP_W,
    parameter int SHW = LFO_SHIFT
) (
    input  logic [FW-1:0] base_freq_i,
    input  logic [SW-1:0] mod_sample_i,
    input  logic [1:0]    lfo_mode_i,
    input  logic          both_play_i,
    output logic [FW-1:0] eff_freq_o
);

    logic [FW-1:0] ext;
    logic [FW-1:0] add;

    always_comb begin
        ext = FW'(mod_sample_i);
        unique case (lfo_mode_i)
            2'd1:    add = ext;
            2'd2:    add = ext << SHW;
            2'd3:    add = ext << (2 * SHW);
            default: add = '0;
        endcase
        eff_freq_o = both_play_i ? (base_freq_i + add) : base_freq_i;
    end

endmodule

// File: rtl/wt_chan.sv
module wt_chan
    import wt_pkg::*;
#(
    parameter int FW        = FREQ_W,
    parameter int SW        = SAMP_W,
    parameter int VW        = VOL_W,
    parameter int DEPTH     = TBL_DEPTH,
    parameter int AW        = TBL_AW,
    parameter bit HAS_NOISE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_i,
    input  cstb_t         stb_i,
    input  logic [7:0]    wdata_i,
    input  logic          step_i,
    input  logic          hold_i,
    output logic [FW-1:0] freq_o,
    output logic [VW-1:0] vol_o,
    output logic [7:0]    bal_o,
    output wmode_e        mode_o,
    output logic [AW-1:0] addr_o,
    output logic [SW-1:0] sample_o,
    output logic [SW-1:0] direct_o,
    output logic [7:0]    noise_o
);

    typedef struct packed {
        logic [FW-1:0]                freq;
        logic [VW-1:0]                vol;
        logic [7:0]                   bal;
        wmode_e                       mode;
        logic [AW-1:0]                addr;
        logic [SW-1:0]                direct;
        logic [7:0]                   noise;
        logic [DEPTH-1:0][SW-1:0]     tbl;
    } chan_st_t;

    chan_st_t q, d;
    cstb_t    wr;
    logic     clr;
    logic     adv;

    always_comb begin
        d  = q;
        wr = sel_i ? stb_i : '0;

        if (wr.flo) d.freq[7:0]    = wdata_i;
        if (wr.fhi) d.freq[FW-1:8] = wdata_i[FW-9:0];
        if (wr.ctl) begin
            d.mode = wmode_e'(wdata_i[7:6]);
            d.vol  = wdata_i[VW-1:0];
        end
        if (wr.bal) d.bal = wdata_i;
        if (wr.noise && HAS_NOISE) d.noise = wdata_i;

        if (wr.dat) begin
            if (q.mode == WM_DIRECT) d.direct = wdata_i[SW-1:0];
            else                     d.tbl[q.addr] = wdata_i[SW-1:0];
        end

        // counter priority: clear beats advance
        clr = (wr.ctl && (wmode_e'(wdata_i[7:6]) == WM_RESET))
            || (q.mode == WM_RESET)
            || hold_i;
        adv = (wr.dat && (q.mode == WM_AUTO))
            || (step_i && (q.mode == WM_PLAY));

        if (clr)      d.addr = '0;
        else if (adv) d.addr = q.addr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign freq_o   = q.freq;
    assign vol_o    = q.vol;
    assign bal_o    = q.bal;
    assign mode_o   = q.mode;
    assign addr_o   = q.addr;
    assign sample_o = q.tbl[q.addr];
    assign direct_o = q.direct;
    assign noise_o  = q.noise;

    // R6
    reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == WM_RESET) |=> (q.addr == '0));

    // R5
    auto_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && stb_i.dat && (q.mode == WM_AUTO) && !hold_i)
        |=> (q.addr == $past(q.addr) + 1'b1));

    // R8
    direct_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && stb_i.dat && (q.mode == WM_DIRECT) && !hold_i)
        |=> ($stable(q.addr) && $stable(q.tbl)));

    // R11
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (q.addr == '0));

endmodule

// File: rtl/wt_regif.sv
module wt_regif
    import wt_pkg::*;
#(
    parameter int NCH   = NUM_CH,
    parameter int FW    = FREQ_W,
    parameter int SW    = SAMP_W,
    parameter int VW    = VOL_W,
    parameter int DEPTH = TBL_DEPTH,
    parameter int AW    = $clog2(DEPTH),
    parameter int SELW  = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [NCH-1:0]    step,
    output logic [7:0]        master_vol,
    output logic [7:0]        lfo_rate,
    output logic [1:0]        lfo_mode,
    output logic              lfo_hold,
    output logic [NCH*FW-1:0] ch_freq,
    output logic [NCH*VW-1:0] ch_vol,
    output logic [NCH*8-1:0]  ch_bal,
    output logic [NCH*2-1:0]  ch_mode,
    output logic [NCH*AW-1:0] ch_addr,
    output logic [NCH*SW-1:0] ch_sample,
    output logic [NCH*SW-1:0] ch_direct,
    output logic [15:0]       noise_ctl,
    output logic [FW-1:0]     ch1_freq_eff
);

    typedef struct packed {
        logic [SELW-1:0] sel;
        logic [7:0]      mvol;
        logic [7:0]      lrate;
        logic [1:0]      lctl;
        logic            ltrig;
    } glob_st_t;

    glob_st_t g_q, g_d;
    gstb_t    gstb;
    cstb_t    cstb;

    wmode_e        mode_w   [NCH];
    logic [SW-1:0] sample_w [NCH];
    logic [7:0]    noise_w  [NCH];

    wt_regdec i_dec (
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .gstb_o    (gstb),
        .cstb_o    (cstb)
    );

    always_comb begin
        g_d = g_q;
        if (gstb.sel)   g_d.sel   = wr_data[SELW-1:0];
        if (gstb.mvol)  g_d.mvol  = wr_data;
        if (gstb.lrate) g_d.lrate = wr_data;
        if (gstb.lctl) begin
            g_d.lctl  = wr_data[1:0];
            g_d.ltrig = wr_data[7];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam bit NOISY = (i >= NCH - 2);

        logic [FW-1:0] f;
        logic [VW-1:0] v;
        logic [7:0]    b;
        logic [AW-1:0] a;
        logic [SW-1:0] dr;

        wt_chan #(
            .FW        (FW),
            .SW        (SW),
            .VW        (VW),
            .DEPTH     (DEPTH),
            .AW        (AW),
            .HAS_NOISE (NOISY)
        ) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel_i    (g_q.sel == SELW'(i)),
            .stb_i    (cstb),
            .wdata_i  (wr_data),
            .step_i   (step[i]),
            .hold_i   ((i == 1) ? g_q.ltrig : 1'b0),
            .freq_o   (f),
            .vol_o    (v),
            .bal_o    (b),
            .mode_o   (mode_w[i]),
            .addr_o   (a),
            .sample_o (sample_w[i]),
            .direct_o (dr),
            .noise_o  (noise_w[i])
        );

        assign ch_freq  [i*FW +: FW] = f;
        assign ch_vol   [i*VW +: VW] = v;
        assign ch_bal   [i*8  +: 8]  = b;
        assign ch_mode  [i*2  +: 2]  = mode_w[i];
        assign ch_addr  [i*AW +: AW] = a;
        assign ch_sample[i*SW +: SW] = sample_w[i];
        assign ch_direct[i*SW +: SW] = dr;
    end

    assign noise_ctl = {noise_w[NCH-1], noise_w[NCH-2]};

    wt_lfo #(
        .FW (FW),
        .SW (SW)
    ) i_lfo (
        .base_freq_i  (ch_freq[FW-1:0]),
        .mod_sample_i (sample_w[1]),
        .lfo_mode_i   (g_q.lctl),
        .both_play_i  ((mode_w[0] == WM_PLAY) && (mode_w[1] == WM_PLAY)),
        .eff_freq_o   (ch1_freq_eff)
    );

    assign master_vol = g_q.mvol;
    assign lfo_rate   = g_q.lrate;
    assign lfo_mode   = g_q.lctl;
    assign lfo_hold   = g_q.ltrig;

    // R12
    lfo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lfo_mode == 2'd0) |-> (ch1_freq_eff == ch_freq[FW-1:0]));

endmodule

// File: tb/test_wt_regif.sv
module test_wt_regif;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [5:0]  step = '0;

    logic [7:0]  master_vol, lfo_rate;
    logic [1:0]  lfo_mode;
    logic        lfo_hold;
    logic [71:0] ch_freq;
    logic [29:0] ch_vol, ch_addr, ch_sample, ch_direct;
    logic [47:0] ch_bal;
    logic [11:0] ch_mode;
    logic [15:0] noise_ctl;
    logic [11:0] ch1_freq_eff;

    always #4 clk = ~clk;

    wt_regif i_wt_regif (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .step(step), .master_vol(master_vol),
        .lfo_rate(lfo_rate), .lfo_mode(lfo_mode), .lfo_hold(lfo_hold),
        .ch_freq(ch_freq), .ch_vol(ch_vol), .ch_bal(ch_bal),
        .ch_mode(ch_mode), .ch_addr(ch_addr), .ch_sample(ch_sample),
        .ch_direct(ch_direct), .noise_ctl(noise_ctl),
        .ch1_freq_eff(ch1_freq_eff)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit started = 0;
    bit done = 0;

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // behavioural reference model
    int m_freq[6], m_vol[6], m_bal[6], m_mode[6], m_addr[6], m_dir[6], m_noise[6];
    int m_tab[6][32];
    int m_sel, m_mvol, m_lrate, m_lctl, m_trig;

    function automatic int m_eff();
        int add;
        add = m_tab[1][m_addr[1]];
        if (m_lctl == 0 || m_mode[0] != 2 || m_mode[1] != 2) return m_freq[0];
        if (m_lctl == 2) add = add * 16;
        if (m_lctl == 3) add = add * 256;
        return (m_freq[0] + add) % 4096;
    endfunction

    always @(posedge clk) begin : mdl
        int na[6];
        int a, d;
        a = int'(wr_addr);
        d = int'(wr_data);
        started = 1;
        if (!rst_n) begin
            for (int c = 0; c < 6; c++) begin
                m_freq[c] = 0; m_vol[c] = 0; m_bal[c] = 0; m_mode[c] = 0;
                m_addr[c] = 0; m_dir[c] = 0; m_noise[c] = 0;
                for (int k = 0; k < 32; k++) m_tab[c][k] = 0;
            end
            m_sel = 0; m_mvol = 0; m_lrate = 0; m_lctl = 0; m_trig = 0;
        end else begin
            for (int c = 0; c < 6; c++) begin
                na[c] = m_addr[c];
                if (wr_en && m_sel == c && a == 6) begin
                    if (m_mode[c] == 3) m_dir[c] = d % 32;
                    else                m_tab[c][m_addr[c]] = d % 32;
                end
                if (wr_en && m_sel == c && a == 4 && (d / 64) == 1) na[c] = 0;
                else if (m_mode[c] == 1) na[c] = 0;
                else if (c == 1 && m_trig == 1) na[c] = 0;
                else if ((wr_en && m_sel == c && a == 6 && m_mode[c] == 0) ||
                         (step[c] && m_mode[c] == 2)) na[c] = (na[c] + 1) % 32;
            end
            for (int c = 0; c < 6; c++) begin
                m_addr[c] = na[c];
                if (wr_en && m_sel == c) begin
                    case (a)
                        2: m_freq[c] = (m_freq[c] / 256) * 256 + d;
                        3: m_freq[c] = (d % 16) * 256 + (m_freq[c] % 256);
                        4: begin m_mode[c] = d / 64; m_vol[c] = d % 32; end
                        5: m_bal[c] = d;
                        7: if (c >= 4) m_noise[c] = d;
                        default: ;
                    endcase
                end
            end
            if (wr_en) begin
                case (a)
                    0: m_sel = d % 8;
                    1: m_mvol = d;
                    8: m_lrate = d;
                    9: begin m_lctl = d % 4; m_trig = d / 128; end
                    default: ;
                endcase
            end
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            for (int c = 0; c < 6; c++) begin
                cmp("R3",  "pitch",  int'(ch_freq[c*12 +: 12]),  m_freq[c]);
                cmp("R4",  "volume", int'(ch_vol[c*5 +: 5]),     m_vol[c]);
                cmp("R4",  "mode",   int'(ch_mode[c*2 +: 2]),    m_mode[c]);
                cmp("R4",  "balance",int'(ch_bal[c*8 +: 8]),     m_bal[c]);
                cmp("R5",  "counter",int'(ch_addr[c*5 +: 5]),    m_addr[c]);
                cmp("R13", "sample", int'(ch_sample[c*5 +: 5]),  m_tab[c][m_addr[c]]);
                cmp("R8",  "direct", int'(ch_direct[c*5 +: 5]),  m_dir[c]);
            end
            cmp("R9",  "noise5",  int'(noise_ctl[7:0]),  m_noise[4]);
            cmp("R9",  "noise6",  int'(noise_ctl[15:8]), m_noise[5]);
            cmp("R10", "mvol",    int'(master_vol),      m_mvol);
            cmp("R10", "rate",    int'(lfo_rate),        m_lrate);
            cmp("R10", "setting", int'(lfo_mode),        m_lctl);
            cmp("R11", "hold",    int'(lfo_hold),        m_trig);
            cmp("R12", "eff",     int'(ch1_freq_eff),    m_eff());
        end
    end

    task automatic cyc(input bit en, input int a, input int d, input int st);
        @(negedge clk);
        #1;
        wr_en   = en;
        wr_addr = a[3:0];
        wr_data = d[7:0];
        step    = st[5:0];
    endtask

    task automatic wr(input int a, input int d);
        cyc(1'b1, a, d, 0);
    endtask

    task automatic settle();
        cyc(1'b0, 0, 0, 0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    logic [71:0] snap_f;
    logic [11:0] snap_m;
    logic [29:0] snap_a;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        cmp("R1", "pitch zero", int'(ch_freq[31:0]), 0);
        cmp("R1", "counters zero", int'(ch_addr), 0);
        cmp("R1", "eff zero", int'(ch1_freq_eff), 0);
        cmp("R1", "mvol zero", int'(master_vol), 0);

        // R3 pitch of channel 1
        wr(0, 0); wr(2, 8'h34); wr(3, 8'hA5); settle();
        cmp("R3", "ch1 pitch", int'(ch_freq[11:0]), 12'h534);

        // R6 address reset mode
        wr(4, 8'h5F); settle();
        cmp("R6", "ch1 mode 1", int'(ch_mode[1:0]), 1);
        wr(6, 8'h07); settle();
        cmp("R6", "counter held", int'(ch_addr[4:0]), 0);
        cmp("R6", "entry 0", int'(ch_sample[4:0]), 7);

        // R5 auto-increment load with wrap
        wr(4, 8'h10);
        for (int i = 0; i < 32; i++) wr(6, (i + 1) % 32);
        settle();
        cmp("R5", "wrapped", int'(ch_addr[4:0]), 0);
        cmp("R5", "entry 0 reloaded", int'(ch_sample[4:0]), 1);
        wr(6, 8'h3F); settle();
        cmp("R5", "counter 1", int'(ch_addr[4:0]), 1);
        cmp("R13", "entry 1", int'(ch_sample[4:0]), 2);

        // channel 2 table, then play
        wr(0, 1); wr(4, 8'h40); wr(4, 8'h00);
        for (int i = 0; i < 32; i++) wr(6, 31 - i);
        wr(4, 8'h85); settle();
        cmp("R13", "ch2 entry 0", int'(ch_sample[9:5]), 31);
        for (int i = 0; i < 3; i++) cyc(1'b0, 0, 0, 2);
        settle();
        cmp("R7", "steps", int'(ch_addr[9:5]), 3);
        // R7 data write and step in one cycle
        cyc(1'b1, 6, 9, 2); settle();
        cmp("R7", "moved once", int'(ch_addr[9:5]), 4);
        cmp("R7", "next entry", int'(ch_sample[9:5]), 27);
        for (int i = 0; i < 31; i++) cyc(1'b0, 0, 0, 2);
        settle();
        cmp("R7", "stored at old addr", int'(ch_sample[9:5]), 9);

        // R12 modulation
        wr(0, 0); wr(4, 8'h9F); settle();
        cmp("R12", "setting 0", int'(ch1_freq_eff), 12'h534);
        wr(9, 1); settle();
        cmp("R12", "setting 1", int'(ch1_freq_eff), 12'h53D);
        wr(9, 2); settle();
        cmp("R12", "setting 2", int'(ch1_freq_eff), 12'h5C4);
        wr(9, 3); settle();
        cmp("R12", "setting 3", int'(ch1_freq_eff), 12'hE34);
        wr(4, 8'h1F); settle();
        cmp("R12", "ch1 not playing", int'(ch1_freq_eff), 12'h534);
        wr(4, 8'h9F);

        // R11 hold flag
        wr(9, 8'h83); settle(); settle();
        cmp("R11", "hold flag", int'(lfo_hold), 1);
        cyc(1'b0, 0, 0, 2); cyc(1'b0, 0, 0, 2); settle();
        cmp("R11", "held at 0", int'(ch_addr[9:5]), 0);
        cmp("R12", "wrap mod 4096", int'(ch1_freq_eff), 12'h434);
        wr(9, 3); cyc(1'b0, 0, 0, 2); settle();
        cmp("R11", "released", int'(ch_addr[9:5]), 1);
        cmp("R12", "eff after release", int'(ch1_freq_eff), 12'h334);

        // R8 direct mode on channel 3
        wr(0, 2); wr(4, 8'hC0); wr(6, 8'h15); settle();
        cmp("R8", "direct out", int'(ch_direct[14:10]), 5'h15);
        cmp("R8", "counter kept", int'(ch_addr[14:10]), 0);
        cmp("R8", "table kept", int'(ch_sample[14:10]), 0);

        // R9 noise byte
        wr(0, 4); wr(7, 8'hAB); wr(0, 2); wr(7, 8'h55); wr(0, 5); wr(7, 8'h66); settle();
        cmp("R9", "ch5 noise", int'(noise_ctl[7:0]), 8'hAB);
        cmp("R9", "ch6 noise", int'(noise_ctl[15:8]), 8'h66);

        // R2 selection outside the channel range
        snap_f = ch_freq; snap_m = ch_mode; snap_a = ch_addr;
        wr(0, 7); wr(2, 8'hFF); wr(4, 8'hFF); wr(6, 8'h11); wr(12, 8'hFF); settle();
        cmp("R2", "pitches untouched", (ch_freq == snap_f) ? 1 : 0, 1);
        cmp("R2", "modes untouched", (ch_mode == snap_m) ? 1 : 0, 1);
        cmp("R2", "counters untouched", (ch_addr == snap_a) ? 1 : 0, 1);

        // R10 global bytes
        wr(1, 8'h3C); wr(8, 8'h77); settle();
        cmp("R10", "master", int'(master_vol), 8'h3C);
        cmp("R10", "rate", int'(lfo_rate), 8'h77);

        // random stream against the model
        for (int k = 0; k < 3000; k++) begin
            int a, d;
            a = $urandom % 16;
            d = $urandom % 256;
            if ((k % 7) == 0) a = 6;
            cyc(($urandom % 4) != 0, a, d, $urandom % 64);
        end
        settle(); settle();
        finish_run();
    end

endmodule